// File: doc/BRIEF.md
# Four-Channel Memory Copy Engine

This block moves data from one memory range to another without processor help. It has four independent channels. Software gives each channel a source address, a destination address and a control word, then turns the channel on through its trigger register. The engine then copies a programmed number of units, each one, two or four bytes wide. It reads one unit, writes it back, and repeats until the count runs out. All memory traffic goes out through one single-beat master port. The engine keeps at most one read outstanding, and every unit is a read followed by a write.

A channel in software mode starts copying as soon as it is switched on. A channel in hardware mode waits until one of two request lines fires: the audio serial port request or the timer request. A per-channel source-select field decides which line the channel listens to. At the end of a transfer, a channel either reloads its working copies of count and addresses and stays on, or it switches itself off. It can also pulse a completion interrupt. When several channels are waiting at once, the lowest-numbered channel runs first.

The memory request side uses valid/ready. Once `mem_valid` is high, the engine keeps address, direction, size and write data unchanged until the cycle in which `mem_ready` is high. A read is complete when `mem_rvalid` returns its data. `mem_rvalid` has no back-pressure. If software clears the on bit in the middle of a transfer, the unit in flight still finishes. The channel then stops without raising an interrupt.

Top module: `dma4_core`

## Requirements
- R1: After reset every channel is off: the on bit (bit 1 of the trigger register, read selector 3) reads 0, no interrupt is raised and no memory request is made.
- R2: Switching a software-mode channel on (bit 23 of the control word is 0) starts its copy with no further stimulus.
- R3: A trigger write acts only when it changes bit 1. Writing 1 to a channel that is already on does not restart it, does not reload it and causes no memory traffic.
- R4: A hardware-mode channel makes no access until a request arrives. The audio request starts channel 2 only, and only when that channel is on, in hardware mode, and has 0 in its source select (bits 25:24).
- R5: The timer request starts channels 0, 2 and 3 when each is on, in hardware mode, and has source select 3. It never starts channel 1.
- R6: A transfer moves exactly as many units as the count in control bits 19:0. The unit is 1 << size bytes, with size in bits 21:20; size code 3 moves four bytes. A count of 0 completes at once, with no memory access.
- R7: Bit 29 of the source or destination register set to 1 keeps that address fixed. Set to 0, the address advances by the unit size after each unit. The address itself is bits 28:0.
- R8: At completion with reload-disable (bit 22) at 0, the current count (read selector 4) returns to the programmed count and the channel stays on.
- R9: At completion with reload-disable at 1, the on bit clears.
- R10: At completion with interrupt enable (bit 28) set, the channel's `irq` bit is high for exactly one cycle. With the bit clear, there is no pulse.
- R11: Channels that are pending together are served in ascending channel number.
- R12: A stalled memory request keeps address and direction until it is accepted. After a read is accepted, no new request is issued until its data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 2 | 0 source, 1 destination, 2 control, 3 trigger |
| wr_data | input | 32 | Write data |
| rd_ch | input | 2 | Channel addressed by the read |
| rd_sel | input | 3 | 0 source, 1 destination, 2 control, 3 trigger, 4 current count, 5 current source, 6 current destination |
| rd_data | output | 32 | Read data (combinational) |
| aud_req | input | 1 | Audio serial port DMA request pulse |
| tmr_req | input | 1 | Timer DMA request pulse |
| irq | output | 4 | Per-channel completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 29 | Byte address |
| mem_size | output | 2 | log2 of bytes in the unit |
| mem_wdata | output | 32 | Write data, unit in the low bytes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, unit in the low bytes |

## Verification
A bad working copy of the count or an address shows up in memory as a misplaced, missing or surplus unit. It also shows in the count read back after completion, one transfer time after the start. A bad on bit or pending flag shows up as a request that is served when it should be dropped, or dropped when it should be served. The bench catches that through unexpected memory accesses or interrupts within a few tens of cycles of the request pulse. A wrong priority shows in the order of the interrupt pulses.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  // Bit positions software relies on
  localparam int ADR_FIX   = 29;
  localparam int CT_DSZ_LO = 20;
  localparam int CT_RLD    = 22;
  localparam int CT_HW     = 23;
  localparam int CT_HSRC_LO = 24;
  localparam int CT_IE     = 28;
  localparam int TG_ON     = 1;

  // Request routing
  localparam int AUD_CH       = 2;
  localparam int TMR_SKIP_CH  = 1;
  localparam logic [1:0] HSRC_AUD = 2'd0;
  localparam logic [1:0] HSRC_TMR = 2'd3;

  typedef enum logic [2:0] {
    E_IDLE, E_CHK, E_RD, E_RW, E_WR, E_FIN
  } eng_st_t;

  // Size code 3 is treated as a word
  function automatic logic [1:0] bus_size(input logic [1:0] dsz);
    return (dsz == 2'd3) ? 2'd2 : dsz;
  endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int IDX = 0,
  parameter int AW  = 29,
  parameter int CW  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          aud_req,
  input  logic          tmr_req,
  input  logic          take,
  input  logic          rd_step,
  input  logic          wr_step,
  input  logic          fin,
  output logic          pend,
  output logic          on,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] cur_cnt,
  output logic [AW:0]   src_reg,
  output logic [AW:0]   dst_reg,
  output logic [31:0]   ctl_reg
);
  localparam bit AUD_OK = (IDX == AUD_CH);
  localparam bit TMR_OK = (IDX != TMR_SKIP_CH);

  logic [1:0]    dsz, hsrc;
  logic          hw, rld_dis, hw_hit, trig_chg;
  logic [AW-1:0] step;

  assign dsz     = ctl_reg[CT_DSZ_LO +: 2];
  assign hsrc    = ctl_reg[CT_HSRC_LO +: 2];
  assign hw      = ctl_reg[CT_HW];
  assign rld_dis = ctl_reg[CT_RLD];
  assign step    = AW'(1) << bus_size(dsz);

  assign hw_hit = on && hw &&
                  ((AUD_OK && aud_req && hsrc == HSRC_AUD) ||
                   (TMR_OK && tmr_req && hsrc == HSRC_TMR));
  assign trig_chg = wr_en && wr_sel == 2'd3 && wr_data[TG_ON] != on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      on      <= 1'b0;
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
      src_reg <= '0;
      dst_reg <= '0;
      ctl_reg <= '0;
    end else begin
      if (wr_en && wr_sel == 2'd0) src_reg <= wr_data[AW:0];
      if (wr_en && wr_sel == 2'd1) dst_reg <= wr_data[AW:0];
      if (wr_en && wr_sel == 2'd2) ctl_reg <= wr_data;
      if (take)   pend <= 1'b0;
      if (hw_hit) pend <= 1'b1;
      if (rd_step && !src_reg[AW]) cur_src <= cur_src + step;
      if (wr_step) begin
        if (!dst_reg[AW]) cur_dst <= cur_dst + step;
        cur_cnt <= cur_cnt - 1'b1;
      end
      if (fin) begin
        if (!rld_dis) begin
          cur_src <= src_reg[AW-1:0];
          cur_dst <= dst_reg[AW-1:0];
          cur_cnt <= ctl_reg[CW-1:0];
        end else begin
          on <= 1'b0;
        end
      end
      if (trig_chg) begin
        on <= wr_data[TG_ON];
        if (wr_data[TG_ON]) begin
          cur_src <= src_reg[AW-1:0];
          cur_dst <= dst_reg[AW-1:0];
          cur_cnt <= ctl_reg[CW-1:0];
          pend    <= !hw;
        end else begin
          pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 29,
  parameter int DW  = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pend_any,
  input  logic [CHW-1:0] pick,
  input  logic           sel_on,
  input  logic           sel_cnt_zero,
  input  logic [AW-1:0]  sel_src,
  input  logic [AW-1:0]  sel_dst,
  input  logic [1:0]     sel_dsz,
  input  logic           mem_ready,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic [CHW-1:0] act,
  output logic           take,
  output logic           rd_step,
  output logic           wr_step,
  output logic           fin,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata
);
  eng_st_t       st;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      act    <= '0;
      data_q <= '0;
    end else begin
      case (st)
        E_IDLE: if (pend_any) begin
          act <= pick;
          st  <= E_CHK;
        end
        E_CHK: begin
          if (sel_cnt_zero) st <= E_FIN;
          else if (!sel_on) st <= E_IDLE;
          else              st <= E_RD;
        end
        E_RD: if (mem_ready) st <= E_RW;
        E_RW: if (mem_rvalid) begin
          data_q <= mem_rdata;
          st     <= E_WR;
        end
        E_WR: if (mem_ready) st <= E_CHK;
        E_FIN: st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign take      = (st == E_IDLE) && pend_any;
  assign rd_step   = (st == E_RD) && mem_ready;
  assign wr_step   = (st == E_WR) && mem_ready;
  assign fin       = (st == E_FIN);
  assign mem_valid = (st == E_RD) || (st == E_WR);
  assign mem_we    = (st == E_WR);
  assign mem_addr  = (st == E_WR) ? sel_dst : sel_src;
  assign mem_size  = bus_size(sel_dsz);
  assign mem_wdata = data_q;
endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 29,
  parameter int CW  = 20,
  parameter int DW  = 32,
  parameter int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [1:0]     wr_sel,
  input  logic [31:0]    wr_data,
  input  logic [CHW-1:0] rd_ch,
  input  logic [2:0]     rd_sel,
  output logic [31:0]    rd_data,
  input  logic           aud_req,
  input  logic           tmr_req,
  output logic [NCH-1:0] irq,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata
);
  logic [NCH-1:0] pend_v, on_v, rld_v, ie_v;
  logic [AW-1:0]  csrc_a [NCH];
  logic [AW-1:0]  cdst_a [NCH];
  logic [CW-1:0]  ccnt_a [NCH];
  logic [AW:0]    src_a  [NCH];
  logic [AW:0]    dst_a  [NCH];
  logic [31:0]    ctl_a  [NCH];

  logic [CHW-1:0] act, pick;
  logic           take, rd_step, wr_step, fin, pend_any;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma4_chan #(.IDX(g), .AW(AW), .CW(CW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && wr_ch == CHW'(g)),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .aud_req (aud_req),
      .tmr_req (tmr_req),
      .take    (take && pick == CHW'(g)),
      .rd_step (rd_step && act == CHW'(g)),
      .wr_step (wr_step && act == CHW'(g)),
      .fin     (fin && act == CHW'(g)),
      .pend    (pend_v[g]),
      .on      (on_v[g]),
      .cur_src (csrc_a[g]),
      .cur_dst (cdst_a[g]),
      .cur_cnt (ccnt_a[g]),
      .src_reg (src_a[g]),
      .dst_reg (dst_a[g]),
      .ctl_reg (ctl_a[g])
    );
    assign rld_v[g] = ctl_a[g][CT_RLD];
    assign ie_v[g]  = ctl_a[g][CT_IE];
    assign irq[g]   = fin && act == CHW'(g) && ie_v[g];
  end

  // Lowest pending channel wins
  always_comb begin
    pick = '0;
    for (int k = NCH - 1; k >= 0; k--)
      if (pend_v[k]) pick = CHW'(k);
  end
  assign pend_any = |pend_v;

  dma4_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CHW(CHW)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_any     (pend_any),
    .pick         (pick),
    .sel_on       (on_v[act]),
    .sel_cnt_zero (ccnt_a[act] == '0),
    .sel_src      (csrc_a[act]),
    .sel_dst      (cdst_a[act]),
    .sel_dsz      (ctl_a[act][CT_DSZ_LO +: 2]),
    .mem_ready    (mem_ready),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .act          (act),
    .take         (take),
    .rd_step      (rd_step),
    .wr_step      (wr_step),
    .fin          (fin),
    .mem_valid    (mem_valid),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_size     (mem_size),
    .mem_wdata    (mem_wdata)
  );

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = 32'(src_a[rd_ch]);
      3'd1:    rd_data = 32'(dst_a[rd_ch]);
      3'd2:    rd_data = ctl_a[rd_ch];
      3'd3:    rd_data = 32'(on_v[rd_ch]) << TG_ON;
      3'd4:    rd_data = 32'(ccnt_a[rd_ch]);
      3'd5:    rd_data = 32'(csrc_a[rd_ch]);
      3'd6:    rd_data = 32'(cdst_a[rd_ch]);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma4_chk.sv
module dma4_chk #(
  parameter int NCH = 4,
  parameter int AW  = 29,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic [NCH-1:0] irq,
  input logic [NCH-1:0] on_v,
  input logic [NCH-1:0] rld_v
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> !mem_valid); // R12

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq)); // R10

  for (genvar g = 0; g < NCH; g++) begin : g_a
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && rld_v[g] |=> !on_v[g]); // R9
    AST_STAY_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && !rld_v[g] |=> on_v[g]); // R8
  end
endmodule

bind dma4_core dma4_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq       (irq),
  .on_v      (on_v),
  .rld_v     (rld_v)
);

// File: tb/test_dma4_core.sv
`timescale 1ns/1ps
module test_dma4_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0, wr_sel = '0, rd_ch = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        aud_req = 1'b0, tmr_req = 1'b0;
  logic [3:0]  irq;
  logic        mem_valid, mem_we, mem_rvalid;
  logic        mem_ready;
  logic [28:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dma4_core i_dma4_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .aud_req(aud_req), .tmr_req(tmr_req), .irq(irq), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  int n_acc = 0, n_proto = 0;
  int irq_n [4] = '{0, 0, 0, 0};
  int ord [16];
  int ord_n = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_m [256];

  // Memory model with random back-pressure
  logic        rdy, rv;
  logic [31:0] rdat, tmp;
  assign mem_ready  = rdy;
  assign mem_rvalid = rv;
  assign mem_rdata  = rdat;

  always @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      rv  <= 1'b0;
      rdat <= '0;
    end else begin
      rdy <= ($urandom % 4) != 0;
      rv  <= 1'b0;
      if (mem_valid && rdy) begin
        n_acc++;
        if (mem_we) begin
          for (int b = 0; b < (1 << mem_size); b++)
            mem[(int'(mem_addr) + b) & 255] = mem_wdata[8*b +: 8];
        end else begin
          tmp = '0;
          for (int b = 0; b < (1 << mem_size); b++)
            tmp[8*b +: 8] = mem[(int'(mem_addr) + b) & 255];
          rdat <= tmp;
          rv   <= 1'b1;
        end
      end
    end
  end

  // Protocol monitor and interrupt log
  logic        pv = 1'b0, pw = 1'b0, racc = 1'b0;
  logic [28:0] pa = '0;
  always @(posedge clk) begin
    if (rst_n) begin
      if (pv && !(mem_valid && mem_addr == pa && mem_we == pw)) n_proto++;
      if (racc && mem_valid) n_proto++;
      pv   = mem_valid && !rdy;
      pa   = mem_addr;
      pw   = mem_we;
      racc = mem_valid && rdy && !mem_we;
      for (int k = 0; k < 4; k++)
        if (irq[k]) begin
          irq_n[k]++;
          if (ord_n < 16) ord[ord_n] = k;
          ord_n++;
        end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_mem(input string tag);
    int bad_i = -1;
    n_chk++;
    for (int i = 0; i < 256; i++)
      if (bad_i < 0 && mem[i] !== ref_m[i]) bad_i = i;
    if (bad_i >= 0) begin
      n_bad++;
      $display("FAIL %s: byte %0d got %0h expected %0h", tag, bad_i, mem[bad_i], ref_m[bad_i]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[1:0]; wr_sel = sel[1:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdreg(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk);
    rd_ch = ch[1:0]; rd_sel = sel[2:0];
    #1 v = rd_data;
  endtask

  task automatic pulse_aud();
    @(negedge clk); aud_req = 1'b1;
    @(negedge clk); aud_req = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_req = 1'b1;
    @(negedge clk); tmr_req = 1'b0;
  endtask

  function automatic logic [31:0] mkctl(input int cnt, input int dsz, input bit rld_dis,
                                        input bit hw, input int hs, input bit ie);
    return 32'(cnt) | (32'(dsz) << 20) | (32'(rld_dis) << 22) | (32'(hw) << 23)
         | (32'(hs) << 24) | (32'(ie) << 28);
  endfunction

  task automatic prog(input int ch, input int src, input bit fs, input int dst,
                      input bit fd, input logic [31:0] ctl);
    wr(ch, 0, (32'(fs) << 29) | 32'(src));
    wr(ch, 1, (32'(fd) << 29) | 32'(dst));
    wr(ch, 2, ctl);
  endtask

  // Reference copy: one unit read, then written, per step
  task automatic ref_copy(input int src, input bit fs, input int dst, input bit fd,
                          input int dsz, input int cnt);
    int n = 1 << ((dsz == 3) ? 2 : dsz);
    int s = src, d = dst;
    logic [7:0] u [4];
    for (int i = 0; i < cnt; i++) begin
      for (int b = 0; b < n; b++) u[b] = ref_m[(s + b) & 255];
      for (int b = 0; b < n; b++) ref_m[(d + b) & 255] = u[b];
      if (!fs) s += n;
      if (!fd) d += n;
    end
  endtask

  logic [31:0] v;
  int a0, i0, base;

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'($urandom);
      ref_m[i] = mem[i];
    end
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    for (int c = 0; c < 4; c++) begin
      rdreg(c, 3, v);
      chk("R1 on bit after reset", v, 32'd0);
    end
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 no request after reset", 32'(mem_valid), 32'd0);

    // R2/R6/R7/R8/R10: software word copy with reload
    prog(1, 8'h00, 0, 8'h80, 0, mkctl(4, 2, 0, 0, 0, 1));
    ref_copy(8'h00, 0, 8'h80, 0, 2, 4);
    i0 = irq_n[1];
    wr(1, 3, 32'h2);
    idle(200);
    chk_mem("R2 R6 R7 software word copy");
    chk("R10 one irq pulse", 32'(irq_n[1] - i0), 32'd1);
    rdreg(1, 4, v); chk("R8 count reloaded", v, 32'd4);
    rdreg(1, 3, v); chk("R8 stays on", v, 32'h2);

    // R3: rewriting the on bit does nothing
    for (int i = 0; i < 16; i++) mem[i] = ~mem[i];
    for (int i = 0; i < 16; i++) ref_m[i] = ~ref_m[i];
    a0 = n_acc; i0 = irq_n[1];
    wr(1, 3, 32'h2);
    idle(100);
    chk_mem("R3 no restart on same value");
    chk("R3 no memory traffic", 32'(n_acc - a0), 32'd0);
    chk("R3 no irq", 32'(irq_n[1] - i0), 32'd0);
    wr(1, 3, 32'h0);

    // R6/R9/R10: zero count
    prog(0, 8'h10, 0, 8'h90, 0, mkctl(0, 0, 1, 0, 0, 1));
    a0 = n_acc; i0 = irq_n[0];
    wr(0, 3, 32'h2);
    idle(30);
    chk("R6 zero count no access", 32'(n_acc - a0), 32'd0);
    chk("R10 zero count irq", 32'(irq_n[0] - i0), 32'd1);
    rdreg(0, 3, v); chk("R9 off after zero count", v, 32'd0);

    // R7/R9: fixed destination bytes, fixed source halfwords
    prog(3, 8'h30, 0, 8'hB0, 1, mkctl(5, 0, 1, 0, 0, 0));
    ref_copy(8'h30, 0, 8'hB0, 1, 0, 5);
    i0 = irq_n[3];
    wr(3, 3, 32'h2);
    idle(150);
    chk_mem("R7 fixed destination");
    chk("R10 no irq when disabled", 32'(irq_n[3] - i0), 32'd0);
    rdreg(3, 3, v); chk("R9 on bit cleared", v, 32'd0);
    rdreg(3, 4, v); chk("R9 count left at zero", v, 32'd0);
    prog(2, 8'h44, 1, 8'hD0, 0, mkctl(3, 1, 1, 0, 0, 0));
    ref_copy(8'h44, 1, 8'hD0, 0, 1, 3);
    wr(2, 3, 32'h2);
    idle(150);
    chk_mem("R7 fixed source");

    // R4/R5: hardware mode on channel 2, audio source
    prog(2, 8'h50, 0, 8'hE0, 0, mkctl(2, 1, 0, 1, 0, 1));
    a0 = n_acc; i0 = irq_n[2];
    wr(2, 3, 32'h2);
    idle(40);
    chk("R4 waits for request", 32'(n_acc - a0), 32'd0);
    pulse_tmr();
    idle(40);
    chk("R5 timer ignored for source 0", 32'(n_acc - a0), 32'd0);
    chk("R5 no irq from timer", 32'(irq_n[2] - i0), 32'd0);
    pulse_aud();
    idle(100);
    ref_copy(8'h50, 0, 8'hE0, 0, 1, 2);
    chk_mem("R4 audio request copy");
    chk("R4 irq after audio request", 32'(irq_n[2] - i0), 32'd1);
    wr(2, 3, 32'h0);

    // R4/R5: channel 1 never answers either request
    prog(1, 8'h60, 0, 8'hF0, 0, mkctl(2, 0, 0, 1, 3, 1));
    a0 = n_acc; i0 = irq_n[1];
    wr(1, 3, 32'h2);
    pulse_tmr();
    pulse_aud();
    idle(60);
    chk("R5 channel 1 ignores timer", 32'(n_acc - a0), 32'd0);
    chk("R4 channel 1 ignores audio", 32'(irq_n[1] - i0), 32'd0);

    // R11/R5: priority among timer-triggered channels
    prog(3, 8'h20, 0, 8'hA0, 0, mkctl(3, 2, 0, 1, 3, 1));
    prog(0, 8'h40, 0, 8'hC0, 0, mkctl(2, 0, 0, 1, 3, 1));
    wr(3, 3, 32'h2);
    wr(0, 3, 32'h2);
    base = ord_n; i0 = irq_n[1];
    pulse_tmr();
    idle(200);
    ref_copy(8'h40, 0, 8'hC0, 0, 0, 2);
    ref_copy(8'h20, 0, 8'hA0, 0, 2, 3);
    chk_mem("R5 timer copies");
    chk("R11 interrupts seen", 32'(ord_n - base), 32'd2);
    chk("R11 first served", 32'(ord[base & 15]), 32'd0);
    chk("R11 second served", 32'(ord[(base + 1) & 15]), 32'd3);
    chk("R5 channel 1 silent", 32'(irq_n[1] - i0), 32'd0);
    wr(0, 3, 32'h0); wr(1, 3, 32'h0); wr(3, 3, 32'h0);

    // Random software transfers
    for (int t = 0; t < 24; t++) begin
      int  ch  = $urandom % 4;
      int  dsz = $urandom % 4;
      int  cnt = 1 + ($urandom % 8);
      int  src = $urandom % 256;
      int  dst = $urandom % 256;
      bit  fs  = ($urandom % 4) == 0;
      bit  fd  = ($urandom % 4) == 0;
      bit  rld = $urandom % 2;
      bit  ie  = $urandom % 2;
      wr(ch, 3, 32'h0);
      prog(ch, src, fs, dst, fd, mkctl(cnt, dsz, rld, 0, 0, ie));
      ref_copy(src, fs, dst, fd, dsz, cnt);
      i0 = irq_n[ch];
      wr(ch, 3, 32'h2);
      idle(150);
      chk_mem("R6 R7 random copy");
      rdreg(ch, 4, v);
      chk("R8 R9 random count", v, rld ? 32'd0 : 32'(cnt));
      rdreg(ch, 3, v);
      chk("R8 R9 random on bit", v, rld ? 32'd0 : 32'h2);
      chk("R10 random irq", 32'(irq_n[ch] - i0), 32'(ie));
    end

    chk("R12 request protocol", 32'(n_proto), 32'd0);
    finish_run();
  end
endmodule